// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Suppression

This block receives characters on a single asynchronous serial line. The line passes through a reset-to-low synchronizer, and reception starts only when a high-to-low transition is seen on the synchronized line. A free-running 16x oversampling tick, supplied from outside, paces the bit slots. Each slot is judged by a majority vote of three mid-slot samples. When a character completes, it is placed in a receive buffer register and a receive request is raised. The request stays up until software (or a transfer engine) strobes a buffer read.

Errors are reported through sticky flags. A framing error is raised when the stop slot votes low. An overrun error, together with a one-cycle error interrupt pulse, is raised when a new character completes while the previous one is still unread. When the line is held low through and beyond the stop slot (a break), the receiver reports exactly one bad frame. It then parks until the line has gone high and a fresh falling edge appears. A read strobe that lands in the very clock of a completion consumes the old character, so no overrun is lost or invented in that window.

The control state machine has five states. IDLE waits for a falling edge. START times the start slot and either rejects a glitch (back to IDLE) or proceeds. DATA collects the data slots. STOP judges the stop slot and completes the character, then goes to IDLE, or goes to HOLD when the stop slot voted low and the line is still low. HOLD waits for the line to return high, then goes to IDLE.

Top module: `brk_uart_rx`

## Requirements
- R1: Reception begins only on a high-to-low transition of the synchronized line; a line that is low from reset onward, or that merely stays low, starts no frame and raises no request.
- R2: A frame is one low start slot, 8 data slots with the least significant bit first, and one stop slot, each 16 ticks long; counting ticks 0 to 15 from the detected edge, each slot's value is the majority of the samples at ticks 7, 8 and 9, so a single contrary sample does not change the received bit.
- R3: A start slot whose vote is high is discarded as a glitch: the receiver returns to idle without updating the buffer or any flag, and the next clean frame is received normally.
- R4: A character completes on the 16th tick of the stop slot; in that same clock edge the buffer output takes the character and the receive request rises, and neither happens earlier.
- R5: A read strobe clears the receive request; a read strobe while the request is low changes neither the request nor the buffer.
- R6: When the stop slot votes low, the character is still stored and the receive request raised, and the framing error flag is set in the same edge.
- R7: After a frame whose stop slot voted low with the line still low, no further frame is received, however long the line stays low, until the line goes high and a new falling edge occurs.
- R8: When a character completes while the request is still set and no read strobe is present in that clock, the overrun flag is set, the error interrupt output pulses for exactly one clock, and the buffer takes the new character.
- R9: A read strobe in the same clock as a completion consumes the previous character: no overrun is flagged and the request stays set for the new character; a read strobe one clock after completion leaves the overrun flag set.
- R10: The framing and overrun flags stay set until the error-clear input is strobed; when a flag is set and cleared in the same clock, setting wins.
- R11: After reset, the buffer output, the request, both error flags and the error interrupt output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | One-clock pulse at 16 times the bit rate |
| rd_i | input | 1 | Receive buffer read strobe |
| err_clr_i | input | 1 | Strobe clearing the framing and overrun flags |
| data_o | output | 8 | Receive buffer contents |
| rx_req_o | output | 1 | Receive request, set on completion, cleared by a read |
| frame_err_o | output | 1 | Sticky framing error flag |
| ovr_err_o | output | 1 | Sticky overrun error flag |
| err_irq_o | output | 1 | One-clock error interrupt pulse on overrun |

## Verification
A falling edge on the line is seen three clocks after it is driven: two synchronizer stages plus the state register. The first counted tick follows that. The buffer, request and error flags all change in the clock edge of the 160th counted tick, and read and clear strobes act in the edge that samples them. The bench issues one tick every four clocks and changes the line in the same clock as each tick. The synchronizer therefore makes each sample see the line value driven one tick earlier, and the bench lays out its slots with that lag. It checks that the request is still low after the 160th line update, before the completion tick, and that the results are present a few clocks after it. Read strobes are placed in the completion clock or one clock later to probe the overrun window. A behavioural model in the bench keeps the expected buffer and flags and counts request rises and interrupt pulses on every clock to detect spurious or missing frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HOLD  = 3'd4
    } srx_state_e;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic line_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Reset to low so that a line already low at reset never looks like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q[0] <= rxd_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign line_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];

    // R1
    line_high_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o && !rxd_i && !chain_q[0] && STAGES == 2) |=> fall_o);

endmodule

// File: rtl/srx_bit_sampler.sv
module srx_bit_sampler #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic line_i,
    output logic slot_end_o,
    output logic bit_o
);

    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    logic [CW-1:0] cnt_q;
    logic [1:0]    votes_q;
    logic          last;
    logic          in_win;

    assign last   = (cnt_q == CW'(OVS - 1));
    assign in_win = (cnt_q == CW'(MID - 1)) || (cnt_q == CW'(MID)) ||
                    (cnt_q == CW'(MID + 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            votes_q <= '0;
        end else if (!run_i) begin
            cnt_q   <= '0;
            votes_q <= '0;
        end else if (tick_i) begin
            if (last) begin
                cnt_q   <= '0;
                votes_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (in_win && line_i) begin
                    votes_q <= votes_q + 1'b1;
                end
            end
        end
    end

    assign slot_end_o = run_i & tick_i & last;
    assign bit_o      = votes_q[1];

    // R2
    votes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(votes_q));

    // R2
    slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end_o |=> (votes_q == 2'd0));

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic          fall_i,
    input  logic          slot_end_i,
    input  logic          bit_i,
    output logic          run_o,
    output logic          done_o,
    output logic          ferr_o,
    output logic [DW-1:0] data_o
);

    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    srx_state_e    state_q, state_d;
    logic [BW-1:0] idx_q;
    logic [DW-1:0] shreg_q;
    logic          last_data;

    assign last_data = (idx_q == BW'(DW - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall_i) state_d = ST_START;
            end
            ST_START: begin
                if (slot_end_i) state_d = bit_i ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (slot_end_i && last_data) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (slot_end_i) begin
                    if (bit_i || line_i) state_d = ST_IDLE;
                    else                 state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (line_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        run_o  = 1'b0;
        done_o = 1'b0;
        ferr_o = 1'b0;
        unique case (state_q)
            ST_START, ST_DATA: run_o = 1'b1;
            ST_STOP: begin
                run_o  = 1'b1;
                done_o = slot_end_i;
                ferr_o = slot_end_i & ~bit_i;
            end
            default: ;
        endcase
    end

    // Data path: bit index and shift register, least significant bit first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            shreg_q <= '0;
        end else if (slot_end_i) begin
            if (state_q == ST_START) begin
                idx_q <= '0;
            end else if (state_q == ST_DATA) begin
                idx_q   <= idx_q + 1'b1;
                shreg_q <= {bit_i, shreg_q[DW-1:1]};
            end
        end
    end

    assign data_o = shreg_q;

    // R1
    idle_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fall_i) |=> (state_q == ST_IDLE));

    // R3
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && slot_end_i && bit_i) |=> (state_q == ST_IDLE));

    // R7
    break_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !bit_i && !line_i) |=> (state_q == ST_HOLD));

    // R7
    hold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !line_i) |=> (state_q == ST_HOLD));

    // R6
    ferr_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |-> done_o);

endmodule

// File: rtl/srx_result_reg.sv
module srx_result_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic          ferr_i,
    input  logic [DW-1:0] data_i,
    input  logic          rd_i,
    input  logic          clr_i,
    output logic [DW-1:0] data_o,
    output logic          req_o,
    output logic          ferr_o,
    output logic          ovr_o,
    output logic          irq_o
);

    logic [DW-1:0] data_q;
    logic          req_q;
    logic          ferr_q;
    logic          ovr_q;
    logic          irq_q;
    logic          lost;

    // A read in the completion clock consumes the old character.
    assign lost = done_i & req_q & ~rd_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            req_q  <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (done_i) data_q <= data_i;

            if (done_i)    req_q <= 1'b1;
            else if (rd_i) req_q <= 1'b0;

            if (done_i && ferr_i) ferr_q <= 1'b1;
            else if (clr_i)       ferr_q <= 1'b0;

            if (lost)       ovr_q <= 1'b1;
            else if (clr_i) ovr_q <= 1'b0;

            irq_q <= lost;
        end
    end

    assign data_o = data_q;
    assign req_o  = req_q;
    assign ferr_o = ferr_q;
    assign ovr_o  = ovr_q;
    assign irq_o  = irq_q;

    // R4
    req_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> req_q);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> !req_q);

    // R6
    ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ferr_i) |=> ferr_q);

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && req_q && !rd_i) |=> (ovr_q && irq_q));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R9
    same_cycle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && rd_i) |=> (req_q && !irq_q));

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_i) |=> ovr_q);

    // R10
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_q && !clr_i) |=> ferr_q);

endmodule

// File: rtl/brk_uart_rx.sv
module brk_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              tick_i,
    input  logic              rd_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              rx_req_o,
    output logic              frame_err_o,
    output logic              ovr_err_o,
    output logic              err_irq_o
);

    logic              line;
    logic              fall;
    logic              run;
    logic              slot_end;
    logic              bit_val;
    logic              done;
    logic              ferr;
    logic [DATA_W-1:0] shdata;

    srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_i  (rxd_i),
        .line_o (line),
        .fall_o (fall)
    );

    srx_bit_sampler #(.OVS(OVS)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick_i),
        .line_i     (line),
        .slot_end_o (slot_end),
        .bit_o      (bit_val)
    );

    srx_frame_fsm #(.DW(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line),
        .fall_i     (fall),
        .slot_end_i (slot_end),
        .bit_i      (bit_val),
        .run_o      (run),
        .done_o     (done),
        .ferr_o     (ferr),
        .data_o     (shdata)
    );

    srx_result_reg #(.DW(DATA_W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .ferr_i (ferr),
        .data_i (shdata),
        .rd_i   (rd_i),
        .clr_i  (err_clr_i),
        .data_o (data_o),
        .req_o  (rx_req_o),
        .ferr_o (frame_err_o),
        .ovr_o  (ovr_err_o),
        .irq_o  (err_irq_o)
    );

endmodule

// File: tb/brk_uart_rx_tb.sv
module brk_uart_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       err_clr_i = 1'b0;
    logic [7:0] data_o;
    logic       rx_req_o;
    logic       frame_err_o;
    logic       ovr_err_o;
    logic       err_irq_o;

    int  checks = 0;
    int  fails = 0;
    int  req_rises = 0;
    int  irq_cycles = 0;
    logic req_d = 1'b0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    brk_uart_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd_i),
        .tick_i      (tick_i),
        .rd_i        (rd_i),
        .err_clr_i   (err_clr_i),
        .data_o      (data_o),
        .rx_req_o    (rx_req_o),
        .frame_err_o (frame_err_o),
        .ovr_err_o   (ovr_err_o),
        .err_irq_o   (err_irq_o)
    );

    // Per-clock observation: request rises and interrupt pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_req_o && !req_d) req_rises++;
            if (err_irq_o) irq_cycles++;
        end
        req_d = rx_req_o;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One oversampling tick: four clocks, line updated with the tick
    task automatic tk(logic line, logic rd_now = 1'b0, logic rd_late = 1'b0,
                      logic clr = 1'b0);
        @(negedge clk);
        rxd_i = line; tick_i = 1'b1; rd_i = rd_now; err_clr_i = clr;
        @(negedge clk);
        tick_i = 1'b0; rd_i = rd_late; err_clr_i = 1'b0;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) tk(1'b1);
    endtask

    // 160 ticks of frame; completion happens on the following tick
    task automatic send(logic [7:0] d, logic stop, int flip = -1);
        for (int c = 0; c < 160; c++) begin
            int   b;
            logic ln;
            b  = c / 16;
            ln = (b == 0) ? 1'b0 : (b == 9) ? stop : d[b-1];
            if (c == flip) ln = ~ln;
            tk(ln);
        end
    endtask

    initial begin
        int base;
        int irq0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 data", data_o, 8'h00);
        check("R11 req", rx_req_o, 1'b0);
        check("R11 ferr", frame_err_o, 1'b0);
        check("R11 ovr", ovr_err_o, 1'b0);
        check("R11 irq", err_irq_o, 1'b0);

        // R1: line low since reset starts nothing
        repeat (200) tk(1'b0);
        check("R1 no frame from low level", req_rises, 0);
        check("R1 req low", rx_req_o, 1'b0);

        // R4 / R2: normal frame
        idle(20);
        send(8'hA5, 1'b1);
        check("R4 not before completion", rx_req_o, 1'b0);
        tk(1'b1);
        check("R4 req on completion", rx_req_o, 1'b1);
        check("R2 data lsb first", data_o, 8'hA5);
        check("R6 no ferr good stop", frame_err_o, 1'b0);

        // R5: read clears, idle read ignored
        tk(1'b1, 1'b1);
        check("R5 read clears", rx_req_o, 1'b0);
        tk(1'b1, 1'b1);
        check("R5 idle read req", rx_req_o, 1'b0);
        check("R5 idle read data", data_o, 8'hA5);

        // R2: one contrary sample at tick 8 of data bit 2
        send(8'h3C, 1'b1, 16 * 3 + 8);
        tk(1'b1);
        check("R2 majority vote", data_o, 8'h3C);
        tk(1'b1, 1'b1);

        // R3: short low pulse is rejected
        base = req_rises;
        repeat (6) tk(1'b0);
        idle(30);
        check("R3 glitch no frame", req_rises, base);
        check("R3 glitch req", rx_req_o, 1'b0);
        send(8'h81, 1'b1);
        tk(1'b1);
        check("R3 recovers", data_o, 8'h81);
        tk(1'b1, 1'b1);

        // R6 / R7: break
        base = req_rises;
        send(8'h00, 1'b0);
        tk(1'b0);
        check("R6 break req", rx_req_o, 1'b1);
        check("R6 break ferr", frame_err_o, 1'b1);
        check("R6 break data", data_o, 8'h00);
        check("R7 one frame", req_rises, base + 1);
        tk(1'b0, 1'b1);
        repeat (400) tk(1'b0);
        check("R7 no more frames", req_rises, base + 1);
        check("R7 req stays low", rx_req_o, 1'b0);
        check("R7 no overrun", ovr_err_o, 1'b0);
        idle(20);
        send(8'h5A, 1'b1);
        tk(1'b1);
        check("R7 after break", data_o, 8'h5A);
        check("R10 ferr sticky", frame_err_o, 1'b1);
        tk(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 ferr cleared", frame_err_o, 1'b0);
        check("R5 read with clear", rx_req_o, 1'b0);

        // R8: overrun
        send(8'h11, 1'b1);
        tk(1'b1);
        irq0 = irq_cycles;
        send(8'h22, 1'b1);
        tk(1'b1);
        check("R8 ovr set", ovr_err_o, 1'b1);
        check("R8 data overwritten", data_o, 8'h22);
        check("R8 req set", rx_req_o, 1'b1);
        check("R8 one irq pulse", irq_cycles, irq0 + 1);
        tk(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 ovr cleared", ovr_err_o, 1'b0);

        // R9: read in completion clock
        send(8'h33, 1'b1);
        tk(1'b1);
        irq0 = irq_cycles;
        send(8'h44, 1'b1);
        tk(1'b1, 1'b1);
        check("R9 same clock req", rx_req_o, 1'b1);
        check("R9 same clock no ovr", ovr_err_o, 1'b0);
        check("R9 same clock no irq", irq_cycles, irq0);
        check("R9 same clock data", data_o, 8'h44);
        tk(1'b1, 1'b1);

        // R9: read one clock late
        send(8'h55, 1'b1);
        tk(1'b1);
        send(8'h66, 1'b1);
        tk(1'b1, 1'b0, 1'b1);
        check("R9 late read ovr", ovr_err_o, 1'b1);
        check("R9 late read req", rx_req_o, 1'b0);
        check("R9 late read data", data_o, 8'h66);
        tk(1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 clear", ovr_err_o, 1'b0);

        // R10: set wins over clear
        send(8'h77, 1'b1);
        tk(1'b1);
        send(8'h88, 1'b0);
        tk(1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 ovr set wins", ovr_err_o, 1'b1);
        check("R10 ferr set wins", frame_err_o, 1'b1);
        idle(20);
        tk(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 final ovr", ovr_err_o, 1'b0);
        check("R10 final ferr", frame_err_o, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule